// File: doc/BRIEF.md
# Buffered Toggle-Flop PWM Generator

This block produces a fixed-period pulse-width modulated signal. A free-running up-counter advances once per prescaled tick and a single toggle flop makes the output waveform. The flop flips once when the count meets the active duty value, and once more when the counter wraps. The output pin always drives the inverse of the flop. The counter width is a parameter, so one PWM period lasts 2^CNT_W ticks. The tick rate comes from a two-bit clock select that picks one of four power-of-two divisors of the system clock, and a doubling input halves whichever rate is picked.

Software loads the duty value through a simple write strobe. While the timer is stopped, a write lands in the compare register at once. While it runs, a write waits in a holding register and moves to the compare register only at the wrap, so a period in progress is never torn. The read port shows the compare value that is in use. A preset input gives the flop its start level, which makes either pulse polarity possible. At every wrap a one-cycle interrupt pulse marks the period boundary.

Top module: `pwm8_toggle`

## Requirements
- R1: While running, each tick that finds the count equal to the active duty value toggles the flop, and the count still advances by one.
- R2: A tick that finds the count at its maximum (all ones) clears the count to zero and toggles the flop. In the cycle after that edge, `ovf_irq` is high for exactly one cycle.
- R3: After synchronous reset the flop is 0, so `pwm_out` is 1. `ovf_irq` is 0, and `rd_data` (the active duty value) is 0.
- R4: `pwm_out` is always the inverse of the flop. With preset level p and duty d, the flop holds p for the first d+1 ticks of each period and holds the inverse of p for the rest. When d is all ones, the match toggle and the wrap toggle fall on the same tick and cancel, so the output stays constant.
- R5: A tick occurs every 2^e system clocks. The exponent e is SHIFT_0, SHIFT_1, SHIFT_2 or SHIFT_3 for `clk_sel` = 0, 1, 2 or 3 (defaults 11, 7, 5, 3). Setting `div_dbl` adds one to e.
- R6: A write (`wr_en` high) while `run` is low sets the active duty value at that edge, and `rd_data` shows it in the next cycle.
- R7: A write while `run` is high goes into the holding register only. The active duty value, and therefore `rd_data`, changes only at the next wrap, where it takes the held value.
- R8: If a write arrives on the same edge as a wrap, the value held before that edge becomes active. The new value stays held until the following wrap.
- R9: While `run` is low, the pin keeps its level (unless the preset changes), no interrupt is raised, and the counter and prescaler are held at zero.
- R10: While stopped, a change on `ff_preset` loads the flop on the next edge. The first running edge loads the flop from `ff_preset`. Changes of `ff_preset` while running have no effect on the output.
- R11: Raising `run` starts from a cleared counter and prescaler. The first tick comes 2^e clocks after the start, and the first wrap comes after a full 2^CNT_W ticks.
- R12: A duty value of 0 toggles the flop on the first tick of each period. No special case exists for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | High runs the timer, low stops it |
| clk_sel | input | 2 | Tick divisor select |
| div_dbl | input | 1 | Doubles the selected divisor |
| ff_preset | input | 1 | Start level of the toggle flop |
| wr_en | input | 1 | Duty write strobe |
| wr_data | input | CNT_W | Duty value to write |
| rd_data | output | CNT_W | Active duty value |
| pwm_out | output | 1 | PWM pin, inverse of the flop |
| ovf_irq | output | 1 | One-cycle pulse after each wrap |

## Verification
The bench builds the block with CNT_W = 4 and divisor exponents 3, 2, 1 and 0. A period is then 16 ticks and a tick can be as fast as every clock. With these values it can sweep every duty value under all eight select and doubling combinations within a short run. Each case starts with a fresh run and covers two and a half periods, comparing the pin and the interrupt at every cycle against arithmetic on the elapsed clock count. The preset is flipped mid-run in each case and stops land mid-period, so the stop, hold and restart paths are covered. A directed run with divisor 1 places one write mid-period and another on the exact wrap edge to check the holding-register transfer.

// File: rtl/pwm8_pkg.sv
// Package: shared helpers for the toggle-flop PWM generator.
// Assumes: nothing beyond elaboration-time integer arithmetic.
package pwm8_pkg;

    // Largest of four elaboration constants, used to size the prescaler.
    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/pwm8_prescaler.sv
// Module: pwm8_prescaler
// Makes a one-cycle tick every 2^e clocks while running. e comes from a
// four-entry exponent table indexed by clk_sel, plus one when div_dbl is set.
// Assumes: PRE_W is at least the largest exponent plus one. The counter is
// held at zero while stopped, so a start always begins a full tick interval.
module pwm8_prescaler #(
    parameter int SHIFT_0 = 11,
    parameter int SHIFT_1 = 7,
    parameter int SHIFT_2 = 5,
    parameter int SHIFT_3 = 3,
    parameter int PRE_W   = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] clk_sel,
    input  logic       div_dbl,
    output logic       tick
);
    localparam int SH_W = $clog2(PRE_W + 1);
    localparam int SHIFT_TAB [4] = '{SHIFT_0, SHIFT_1, SHIFT_2, SHIFT_3};

    logic [PRE_W-1:0] pre_cnt;
    logic [SH_W-1:0]  shift_amt;
    logic [PRE_W:0]   span;
    logic [PRE_W-1:0] mask;

    // Prescale counter: free-runs while running, held cleared while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)      pre_cnt <= '0;
        else if (!run)   pre_cnt <= '0;
        else             pre_cnt <= pre_cnt + 1'b1;
    end

    // Exponent selection and low-bit mask of the chosen divisor.
    always_comb begin
        shift_amt = SH_W'(SHIFT_TAB[clk_sel]) + SH_W'(div_dbl);
        span      = ({{PRE_W{1'b0}}, 1'b1} << shift_amt) - {{PRE_W{1'b0}}, 1'b1};
        mask      = span[PRE_W-1:0];
    end

    // Tick when every masked low bit of the counter is set.
    assign tick = run && ((pre_cnt & mask) == mask);

    AST_PRE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pre_cnt == '0)) else $error("prescaler not cleared"); // R9

endmodule

// File: rtl/pwm8_duty_buf.sv
// Module: pwm8_duty_buf
// Double buffer for the duty value. A write while stopped goes straight to
// the active register. A write while running waits in the holding register,
// and the held value moves to the active register on each wrap event.
// Assumes: wrap_evt is asserted only while run is high.
module pwm8_duty_buf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         wrap_evt,
    output logic [W-1:0] active
);
    logic [W-1:0] held;

    // Holding register: captures every write.
    always_ff @(posedge clk) begin
        if (!rst_n)     held <= '0;
        else if (wr_en) held <= wr_data;
    end

    // Active register: direct load while stopped, held value at each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)              active <= '0;
        else if (wr_en && !run)  active <= wr_data;
        else if (wrap_evt)       active <= held;
    end

    AST_STOPPED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !run) |=> (active == $past(wr_data))) else $error("direct load"); // R6
    AST_ACTIVE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wrap_evt) |=> $stable(active)) else $error("active moved"); // R7
    AST_WRAP_TAKES_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_evt && wr_en) |=> (active == $past(held))) else $error("collision"); // R8

endmodule

// File: rtl/pwm8_core.sv
// Module: pwm8_core
// Up-counter plus toggle flop. On each tick the flop flips when the count
// equals the duty value, and again when the count wraps from all ones.
// Both flips on one tick cancel. Also produces the registered wrap pulse.
// Assumes: tick is only high while run is high. ff_preset is a level
// that may change at any time; it acts only while stopped or at start.
module pwm8_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] duty,
    input  logic         ff_preset,
    output logic         wrap_evt,
    output logic         flop,
    output logic         ovf_irq
);
    localparam logic [W-1:0] CNT_MAX = '1;

    logic [W-1:0] cnt;
    logic         run_q;
    logic         preset_q;
    logic         match;
    logic         start;
    logic         base;

    // Event decode for the current tick.
    always_comb begin
        wrap_evt = tick && (cnt == CNT_MAX);
        match    = tick && (cnt == duty);
        start    = run && !run_q;
        base     = start ? ff_preset : flop;
    end

    // Counter: cleared while stopped, advances and wraps on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (!run)     cnt <= '0;
        else if (wrap_evt) cnt <= '0;
        else if (tick)     cnt <= cnt + 1'b1;
    end

    // Edge history of run and of the preset level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            preset_q <= 1'b0;
        end else begin
            run_q    <= run;
            preset_q <= ff_preset;
        end
    end

    // Toggle flop: preset while stopped on a change, toggles while running.
    always_ff @(posedge clk) begin
        if (!rst_n)                      flop <= 1'b0;
        else if (run)                    flop <= base ^ (match ^ wrap_evt);
        else if (ff_preset != preset_q)  flop <= ff_preset;
    end

    // Registered one-cycle wrap pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_irq <= 1'b0;
        else        ovf_irq <= wrap_evt;
    end

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq |=> !ovf_irq) else $error("irq too long"); // R2
    AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq |-> (cnt == '0)) else $error("irq without wrap"); // R2
    AST_CNT_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0)) else $error("count not cleared"); // R9
    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && (ff_preset == preset_q)) |=> $stable(flop)) else $error("pin moved"); // R9
    AST_PRESET_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && (ff_preset != preset_q)) |=> (flop == $past(ff_preset))) else $error("preset"); // R10

endmodule

// File: rtl/pwm8_toggle.sv
// Module: pwm8_toggle (top)
// Buffered toggle-flop PWM: prescaler, double-buffered duty register and
// counter/flop core. The pin drives the inverse of the flop.
// Assumes: CNT_W >= 1. Exponent parameters are non-negative.
module pwm8_toggle #(
    parameter int CNT_W   = 8,
    parameter int SHIFT_0 = 11,
    parameter int SHIFT_1 = 7,
    parameter int SHIFT_2 = 5,
    parameter int SHIFT_3 = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [1:0]       clk_sel,
    input  logic             div_dbl,
    input  logic             ff_preset,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] rd_data,
    output logic             pwm_out,
    output logic             ovf_irq
);
    import pwm8_pkg::*;

    localparam int PRE_W = max_of4(SHIFT_0, SHIFT_1, SHIFT_2, SHIFT_3) + 1;

    logic             tick;
    logic             wrap_evt;
    logic             flop;
    logic [CNT_W-1:0] active;

    pwm8_prescaler #(
        .SHIFT_0 (SHIFT_0), .SHIFT_1 (SHIFT_1),
        .SHIFT_2 (SHIFT_2), .SHIFT_3 (SHIFT_3),
        .PRE_W   (PRE_W)
    ) u_pre (
        .clk (clk), .rst_n (rst_n), .run (run),
        .clk_sel (clk_sel), .div_dbl (div_dbl), .tick (tick)
    );

    pwm8_duty_buf #(.W (CNT_W)) u_buf (
        .clk (clk), .rst_n (rst_n), .run (run), .wr_en (wr_en),
        .wr_data (wr_data), .wrap_evt (wrap_evt), .active (active)
    );

    pwm8_core #(.W (CNT_W)) u_core (
        .clk (clk), .rst_n (rst_n), .run (run), .tick (tick),
        .duty (active), .ff_preset (ff_preset), .wrap_evt (wrap_evt),
        .flop (flop), .ovf_irq (ovf_irq)
    );

    assign rd_data = active;
    assign pwm_out = ~flop;

    AST_PIN_INVERSE: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_out != flop) else $error("pin not inverse"); // R4

endmodule

// File: tb/pwm8_toggle_tb_top.sv
module pwm8_toggle_tb_top;
    localparam int W = 4;
    localparam int PER = 1 << W;
    localparam int SH [4] = '{3, 2, 1, 0};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         run = 1'b0;
    logic [1:0]   clk_sel = 2'd0;
    logic         div_dbl = 1'b0;
    logic         ff_preset = 1'b0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_data;
    logic         pwm_out;
    logic         ovf_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pwm8_toggle #(.CNT_W (W), .SHIFT_0 (3), .SHIFT_1 (2), .SHIFT_2 (1), .SHIFT_3 (0)) dut_i (
        .clk (clk), .rst_n (rst_n), .run (run), .clk_sel (clk_sel),
        .div_dbl (div_dbl), .ff_preset (ff_preset), .wr_en (wr_en),
        .wr_data (wr_data), .rd_data (rd_data), .pwm_out (pwm_out),
        .ovf_irq (ovf_irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // One sweep case: load duty while stopped, run 2.5 periods, stop mid-period.
    task automatic run_case(input int sel, input int dbl, input bit p, input int d);
        int x;
        int total;
        bit hold_pin;
        x = SH[sel] + dbl;
        total = (2 * PER + PER / 2) << x;
        ff_preset = ~p;
        @(negedge clk);
        ff_preset = p;
        wr_en = 1'b1;
        wr_data = W'(d);
        @(negedge clk);
        wr_en = 1'b0;
        chk(rd_data == W'(d), "R6", int'(rd_data), d);
        chk(pwm_out == ~p, "R10", int'(pwm_out), int'(~p));
        clk_sel = 2'(sel);
        div_dbl = dbl[0];
        run = 1'b1;
        for (int n = 1; n <= total; n++) begin
            int t;
            int u;
            bit eff;
            bit eirq;
            @(negedge clk);
            t = n >> x;
            u = t % PER;
            eff = p ^ (u > d);
            eirq = ((n % (1 << x)) == 0) && (u == 0) && (t > 0);
            if (d == 0) chk(pwm_out == ~eff, "R12", int'(pwm_out), int'(~eff));
            else if (d == PER - 1) chk(pwm_out == ~eff, "R4", int'(pwm_out), int'(~eff));
            else chk(pwm_out == ~eff, "R1", int'(pwm_out), int'(~eff));
            chk(ovf_irq == eirq, "R2_R5_R11", int'(ovf_irq), int'(eirq));
            if (n == PER) ff_preset = ~p;
        end
        hold_pin = pwm_out;
        run = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(pwm_out == hold_pin, "R9", int'(pwm_out), int'(hold_pin));
            chk(ovf_irq == 1'b0, "R9", int'(ovf_irq), 0);
        end
    endtask

    // Directed buffer test at divisor 1: mid-period write and wrap collision.
    task automatic buffer_test();
        int dq [4] = '{5, 9, 9, 12};
        ff_preset = 1'b1;
        @(negedge clk);
        ff_preset = 1'b0;
        wr_en = 1'b1;
        wr_data = 4'd5;
        @(negedge clk);
        wr_en = 1'b0;
        clk_sel = 2'd3;
        div_dbl = 1'b0;
        run = 1'b1;
        for (int n = 1; n < 4 * PER; n++) begin
            bit eff;
            @(negedge clk);
            wr_en = 1'b0;
            eff = (n % PER) > dq[n / PER];
            chk(pwm_out == ~eff, "R7", int'(pwm_out), int'(~eff));
            if (n == 11) chk(rd_data == 4'd5, "R7", int'(rd_data), 5);
            if (n == 16) chk(rd_data == 4'd9, "R7", int'(rd_data), 9);
            if (n == 32) chk(rd_data == 4'd9, "R8", int'(rd_data), 9);
            if (n == 48) chk(rd_data == 4'd12, "R8", int'(rd_data), 12);
            if (n == 10) begin wr_en = 1'b1; wr_data = 4'd9; end
            if (n == 31) begin wr_en = 1'b1; wr_data = 4'd12; end
        end
        run = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pwm_out == 1'b1, "R3", int'(pwm_out), 1);
        chk(ovf_irq == 1'b0, "R3", int'(ovf_irq), 0);
        chk(rd_data == '0, "R3", int'(rd_data), 0);
        buffer_test();
        for (int sel = 0; sel < 4; sel++)
            for (int dbl = 0; dbl < 2; dbl++)
                for (int d = 0; d < PER; d++)
                    run_case(sel, dbl, bit'((d ^ sel ^ dbl) & 1), d);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule